// File: doc/BRIEF.md
# Multislope Integrating Converter Sequencer

This block is the digital timing core of a multislope integrating converter. It drives the switch selects for the input path and for the positive and negative reference paths. It also drives the integrator reset and the selector that swaps the input for a zero source. It samples a synchronous comparator bit, where 1 means the integrator is above zero.

Each reading runs in a fixed order:
- an integrator reset;
- a run-up of fixed length, in which the input is integrated while reference pulses give feedback;
- an upward coarse stage, then a downward coarse stage;
- one fine slope, made by driving both reference paths at once.

The block counts the run-up decisions and the rundown clocks, and from them forms a signed raw value. Readings follow a schedule of zero readings and signal readings. Each signal result has the latest zero raw value subtracted from it, which removes the offset caused by switch charge injection. That offset is constant because every switch toggles the same number of times in every reading.

A single `start` pulse requests a reading. The result is a plain register that is updated together with a one-cycle `done` pulse. There is no back-pressure on the result: it is overwritten by the next reading, so a consumer must capture it within the minimum reading time.

Top module: `msadc_seq`

## Requirements
- R1: After reset, all switch selects, `int_rst`, `sel_zero`, `busy`, `done` and `res_zero` are 0, and `result` is 0.
- R2: After an accepted `start`, `int_rst` is high for exactly RST_CYC cycles. Then `sw_in` is high for exactly N_PER*PER_CYC consecutive cycles. Outside that window `sw_in` is 0, and while `int_rst` is high no other select is on.
- R3: Every run-up period lasts PER_CYC cycles and has the following slot layout:
  - a positive pulse from slot 0;
  - one idle slot;
  - a negative pulse;
  - an idle last slot.
  The pulse widths are chosen from the comparator at the start of the period:
  - comparator 1 (with the same value as the previous period, or in the first period): positive long, negative short;
  - comparator 0 under the same conditions: positive short, negative long;
  - comparator value changed since the previous period: both pulses of equal width.
  Long = PER_CYC-2-SHORT_CYC and Mid = (PER_CYC-2)/2, so each period has PER_CYC-2 reference-on cycles.
- R4: In every reading, `sw_pos` and `sw_neg` each rise exactly N_PER+2 times, whatever the input value.
- R5: Break-before-make: no select among `sw_in`, `sw_pos` and `sw_neg` rises in the same cycle that another of them falls.
- R6: The rundown begins with `sw_in` off and one idle cycle. The upward stage (`sw_neg` only) lasts at least one cycle and ends at the first clock that sees the comparator at 1. After one idle cycle, the downward stage (`sw_pos` only) ends at the first clock that sees the comparator at 0.
- R7: The downward stage continues for exactly `rd_ext` extra cycles after the clock that sees the comparator at 0, to compensate for the comparator path delay.
- R8: After one idle cycle, the fine slope drives `sw_pos` and `sw_neg` together until the first clock that sees the comparator at 1.
- R9: raw = (P−N)×K_COARSE + (Cp−Cn)×K_RD − F, where:
  - P and N are the counts of positive-long and negative-long periods;
  - Cp and Cn are the counts of `sw_pos`-only and `sw_neg`-only rundown cycles;
  - F is the count of fine-slope cycles.
- R10: The first reading after reset is a zero reading. Each zero reading is followed by SIG_PER_ZERO signal readings, and then the pattern repeats. `sel_zero` is 1 throughout a zero reading and 0 throughout a signal reading.
- R11: A zero reading stores its raw value and reports it with `res_zero`=1. A signal reading reports raw minus the latest stored zero raw value, with `res_zero`=0.
- R12: `done` is high for exactly one cycle, in the cycle in which `result` and `res_zero` change. `busy` is high from the cycle after an accepted start until that cycle. A `start` while busy is ignored. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one reading (accepted when not busy) |
| cmp | input | 1 | Synchronous comparator, 1 = integrator above zero |
| rd_ext | input | EW | Extra downward cycles after the comparator trip |
| sw_in | output | 1 | Input path to integrator (else ground) |
| sw_pos | output | 1 | Positive reference path to integrator (else ground) |
| sw_neg | output | 1 | Negative reference path to integrator (else ground) |
| int_rst | output | 1 | Integrator reset switch |
| sel_zero | output | 1 | Input selector on zero source |
| busy | output | 1 | Reading in progress |
| done | output | 1 | One-cycle pulse with the result update |
| res_zero | output | 1 | Result came from a zero reading |
| result | output | RW | Signed result |

## Verification
The cycle that retires a reading (`done`, the result update and the advance of the zero schedule) is also the first cycle in which a new `start` can be taken. The bench drives `start` high in exactly that `done` cycle. It then judges that `busy` rises at once, that the chained reading has the zero/signal type the schedule predicts, and that its result uses the zero value stored one cycle earlier. A second coincidence is a `start` pulse in the middle of a reading. That pulse must leave both the count of `done` pulses and the schedule unchanged.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_RUN, S_RGAP, S_UP, S_G1, S_DOWN, S_EXT, S_G2, S_FINE, S_CALC
  } phase_t;

  typedef enum logic [1:0] {
    M_POS, M_NEG, M_BAL
  } pmode_t;
endpackage

// File: rtl/msadc_runup_pat.sv
module msadc_runup_pat
  import msadc_pkg::*;
#(
  parameter int PER_CYC   = 8,
  parameter int SHORT_CYC = 1,
  localparam int SW = $clog2(PER_CYC)
) (
  input  pmode_t        mode,
  input  logic [SW-1:0] slot,
  output logic          pat_pos,
  output logic          pat_neg
);
  localparam int LONG_CYC = PER_CYC - 2 - SHORT_CYC;
  localparam int MID_CYC  = (PER_CYC - 2) / 2;

  logic [SW:0] wp, wn, s_ext;

  always_comb begin
    case (mode)
      M_POS:   begin wp = (SW+1)'(LONG_CYC);  wn = (SW+1)'(SHORT_CYC); end
      M_NEG:   begin wp = (SW+1)'(SHORT_CYC); wn = (SW+1)'(LONG_CYC);  end
      default: begin wp = (SW+1)'(MID_CYC);   wn = (SW+1)'(MID_CYC);   end
    endcase
    s_ext   = {1'b0, slot};
    pat_pos = s_ext < wp;
    pat_neg = (s_ext > wp) && (s_ext <= wp + wn);
  end
endmodule

// File: rtl/msadc_zero_sched.sv
module msadc_zero_sched #(
  parameter int SIG_PER_ZERO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic is_zero
);
  localparam int ZW = (SIG_PER_ZERO < 1) ? 1 : $clog2(SIG_PER_ZERO + 1);

  logic [ZW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else if (adv) pos_q <= (pos_q == ZW'(SIG_PER_ZERO)) ? '0 : pos_q + ZW'(1);
  end

  assign is_zero = (pos_q == '0);
endmodule

// File: rtl/msadc_combine.sv
module msadc_combine #(
  parameter int PW        = 5,
  parameter int CW        = 12,
  parameter int RW        = 24,
  parameter int K_COARSE  = 64,
  parameter int K_RD      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calc,
  input  logic                 is_zero,
  input  logic [PW-1:0]        n_pos,
  input  logic [PW-1:0]        n_neg,
  input  logic [CW-1:0]        c_pos,
  input  logic [CW-1:0]        c_neg,
  input  logic [CW-1:0]        c_fine,
  output logic signed [RW-1:0] result,
  output logic                 res_zero,
  output logic                 done
);
  localparam logic signed [RW-1:0] KC = RW'(K_COARSE);
  localparam logic signed [RW-1:0] KR = RW'(K_RD);

  logic signed [RW-1:0] d_per, d_rd, raw, zero_q;

  always_comb begin
    d_per = $signed(RW'(n_pos)) - $signed(RW'(n_neg));
    d_rd  = $signed(RW'(c_pos)) - $signed(RW'(c_neg));
    raw   = d_per * KC + d_rd * KR - $signed(RW'(c_fine));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      res_zero <= 1'b0;
      done     <= 1'b0;
      zero_q   <= '0;
    end else begin
      done <= calc;
      if (calc) begin
        res_zero <= is_zero;
        if (is_zero) begin
          result <= raw;
          zero_q <= raw;
        end else begin
          result <= raw - zero_q;
        end
      end
    end
  end
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int N_PER        = 16,
  parameter int PER_CYC      = 8,
  parameter int SHORT_CYC    = 1,
  parameter int RST_CYC      = 4,
  parameter int SIG_PER_ZERO = 2,
  parameter int K_COARSE     = 64,
  parameter int K_RD         = 16,
  parameter int EW           = 4,
  parameter int CW           = 12,
  parameter int RW           = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 cmp,
  input  logic [EW-1:0]        rd_ext,
  output logic                 sw_in,
  output logic                 sw_pos,
  output logic                 sw_neg,
  output logic                 int_rst,
  output logic                 sel_zero,
  output logic                 busy,
  output logic                 done,
  output logic                 res_zero,
  output logic signed [RW-1:0] result
);
  localparam int SW = $clog2(PER_CYC);
  localparam int IW = (N_PER < 2) ? 1 : $clog2(N_PER);
  localparam int PW = $clog2(N_PER + 1);
  localparam int RB = $clog2(RST_CYC + 1);
  localparam int TW = (EW > RB) ? EW : RB;

  phase_t        st;
  pmode_t        mode, mode_nx;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] scnt;
  logic [IW-1:0] pidx;
  logic          prev_cmp;
  logic [PW-1:0] n_pos, n_neg;
  logic [CW-1:0] c_pos, c_neg, c_fine;
  logic          pat_pos, pat_neg, is_zero, calc, take_dec;
  logic          rst_last, per_wrap, last_per, go;

  function automatic pmode_t pick(input logic c, input logic p, input logic first);
    if (first || (c == p)) return c ? M_POS : M_NEG;
    return M_BAL;
  endfunction

  assign go       = (st == S_IDLE) && start;
  assign rst_last = (tcnt == TW'(RST_CYC - 1));
  assign per_wrap = (scnt == SW'(PER_CYC - 1));
  assign last_per = (pidx == IW'(N_PER - 1));
  assign mode_nx  = pick(cmp, prev_cmp, st == S_RST);
  assign take_dec = ((st == S_RST) && rst_last) ||
                    ((st == S_RUN) && per_wrap && !last_per);
  assign calc     = (st == S_CALC);

  // phase sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      scnt <= '0;
      pidx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin st <= S_RST; tcnt <= '0; end
        S_RST: begin
          if (rst_last) begin st <= S_RUN; scnt <= '0; pidx <= '0; end
          else tcnt <= tcnt + TW'(1);
        end
        S_RUN: begin
          if (per_wrap) begin
            scnt <= '0;
            if (last_per) st <= S_RGAP;
            else pidx <= pidx + IW'(1);
          end else scnt <= scnt + SW'(1);
        end
        S_RGAP: st <= S_UP;
        S_UP:   if (cmp) st <= S_G1;
        S_G1:   st <= S_DOWN;
        S_DOWN: begin
          if (!cmp) begin
            tcnt <= '0;
            st   <= (rd_ext == '0) ? S_G2 : S_EXT;
          end
        end
        S_EXT: begin
          if ((tcnt + TW'(1)) == TW'(rd_ext)) st <= S_G2;
          else tcnt <= tcnt + TW'(1);
        end
        S_G2:   st <= S_FINE;
        S_FINE: if (cmp) st <= S_CALC;
        default: st <= S_IDLE;
      endcase
    end
  end

  // run-up feedback decision and period tally
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_BAL;
      prev_cmp <= 1'b0;
      n_pos    <= '0;
      n_neg    <= '0;
    end else if (go) begin
      n_pos <= '0;
      n_neg <= '0;
    end else if (take_dec) begin
      mode     <= mode_nx;
      prev_cmp <= cmp;
      if (mode_nx == M_POS) n_pos <= n_pos + PW'(1);
      else if (mode_nx == M_NEG) n_neg <= n_neg + PW'(1);
    end
  end

  // rundown clock tally
  always_ff @(posedge clk) begin
    if (!rst_n || go) begin
      c_pos  <= '0;
      c_neg  <= '0;
      c_fine <= '0;
    end else begin
      case (st)
        S_UP:          c_neg  <= c_neg + CW'(1);
        S_DOWN, S_EXT: c_pos  <= c_pos + CW'(1);
        S_FINE:        c_fine <= c_fine + CW'(1);
        default: ;
      endcase
    end
  end

  msadc_runup_pat #(.PER_CYC(PER_CYC), .SHORT_CYC(SHORT_CYC)) u_pat (
    .mode   (mode),
    .slot   (scnt),
    .pat_pos(pat_pos),
    .pat_neg(pat_neg)
  );

  msadc_zero_sched #(.SIG_PER_ZERO(SIG_PER_ZERO)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (calc),
    .is_zero(is_zero)
  );

  msadc_combine #(
    .PW(PW), .CW(CW), .RW(RW), .K_COARSE(K_COARSE), .K_RD(K_RD)
  ) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .calc    (calc),
    .is_zero (is_zero),
    .n_pos   (n_pos),
    .n_neg   (n_neg),
    .c_pos   (c_pos),
    .c_neg   (c_neg),
    .c_fine  (c_fine),
    .result  (result),
    .res_zero(res_zero),
    .done    (done)
  );

  // switch decode: unused paths sit on ground
  assign int_rst  = (st == S_RST);
  assign sw_in    = (st == S_RUN);
  assign sw_pos   = ((st == S_RUN) && pat_pos) || (st == S_DOWN) ||
                    (st == S_EXT) || (st == S_FINE);
  assign sw_neg   = ((st == S_RUN) && pat_neg) || (st == S_UP) || (st == S_FINE);
  assign busy     = (st != S_IDLE);
  assign sel_zero = busy && is_zero;
endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk #(
  parameter int RW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_in,
  input logic                 sw_pos,
  input logic                 sw_neg,
  input logic                 int_rst,
  input logic                 sel_zero,
  input logic                 busy,
  input logic                 done,
  input logic                 res_zero,
  input logic signed [RW-1:0] result
);
  a_r5_bbm_pos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_pos) |-> !$fell(sw_neg) && !$fell(sw_in));
  a_r5_bbm_neg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_neg) |-> !$fell(sw_pos) && !$fell(sw_in));
  a_r5_bbm_in: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_in) |-> !$fell(sw_pos) && !$fell(sw_neg));
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in |-> busy && !int_rst);
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> !sw_pos && !sw_neg && !sw_in);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(res_zero));
  a_r10_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(sel_zero));
endmodule

bind msadc_seq msadc_seq_chk #(.RW(RW)) u_chk (.*);

// File: tb/tb_msadc_seq.sv
module tb_msadc_seq;
  localparam int BN = 16, BPER = 8, BRST = 4, BKC = 64, BKRD = 16, BSIGZ = 2;
  localparam int BDIFF = 4;   // long minus short pulse width
  localparam int IP = 64, IN = 68;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp = 1'b0;
  logic [3:0] rd_ext = '0;
  logic sw_in, sw_pos, sw_neg, int_rst, sel_zero, busy, done, res_zero;
  logic signed [23:0] result;

  int total = 0, bad = 0;
  int vin = 0, v = 0;
  int rst_c, in_c, ru_p, ru_n, cp, cn, cf, rise_p, rise_n, bbm, ov_up, ov_fine, ext_c, zbad;
  int done_tot = 0, rd_idx = 0, zero_ref = 0, prev_t = 0;
  logic pp = 0, pn = 0, pi = 0, mon_zero = 0;
  logic signed [23:0] r_hi, r_lo;

  always #10 clk = ~clk;

  msadc_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp), .rd_ext(rd_ext),
    .sw_in(sw_in), .sw_pos(sw_pos), .sw_neg(sw_neg), .int_rst(int_rst),
    .sel_zero(sel_zero), .busy(busy), .done(done), .res_zero(res_zero), .result(result)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    rst_c = 0; in_c = 0; ru_p = 0; ru_n = 0; cp = 0; cn = 0; cf = 0;
    rise_p = 0; rise_n = 0; bbm = 0; ov_up = 0; ov_fine = 0; ext_c = 0; zbad = 0;
  endtask

  // integrator model and pin observer
  always @(negedge clk) begin
    int t;
    if (done) done_tot++;
    t = 0;
    if (busy && (sel_zero !== mon_zero)) zbad++;
    if (int_rst) begin
      rst_c++;
    end else if (sw_in) begin
      in_c++;
      if (sw_pos) ru_p++;
      if (sw_neg) ru_n++;
    end else begin
      if (sw_pos && !sw_neg) begin cp++; t = 2; end
      if (sw_neg && !sw_pos) begin cn++; t = 1; end
      if (sw_pos && sw_neg)  begin cf++; t = 3; end
    end
    if (t == 1 && prev_t == 1 && cmp) ov_up++;
    if (t == 3 && prev_t == 3 && cmp) ov_fine++;
    if (t == 2 && prev_t == 2 && !cmp) ext_c++;
    if (sw_pos && !pp) rise_p++;
    if (sw_neg && !pn) rise_n++;
    if ((sw_pos && !pp || sw_neg && !pn || sw_in && !pi) &&
        (!sw_pos && pp || !sw_neg && pn || !sw_in && pi)) bbm++;
    if (int_rst) v = 0;
    else begin
      if (sw_in && !sel_zero) v = v + vin;
      if (sw_pos) v = v - IP;
      if (sw_neg) v = v + IN;
    end
    cmp <= (v > 0);
    pp = sw_pos; pn = sw_neg; pi = sw_in; prev_t = t;
  end

  // one reading; chain=1 raises start in the done cycle; pre=1 means start already high
  task automatic run_reading(input int vi, input int ext, input logic extra,
                             input logic chain, input logic pre, output logic signed [23:0] res);
    int n, raw, expv;
    logic ez;
    ez = ((rd_idx % (BSIGZ + 1)) == 0);
    mon_zero = ez;
    vin = vi;
    rd_ext = 4'(ext);
    if (!pre) begin
      clear_stats();
      @(negedge clk) start = 1'b1;
    end
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R12 busy after start", int'(busy), 1);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
      if (extra && n == 40) start = 1'b1;
      if (extra && n == 41) start = 1'b0;
    end
    chk(n < 3000, "R12 done reached", n, 0);
    #5;
    res = result;
    raw = ((ru_p - ru_n) / BDIFF) * BKC + (cp - cn) * BKRD - cf;
    chk(rst_c == BRST, "R2 reset cycles", rst_c, BRST);
    chk(in_c == BN * BPER, "R2 input window", in_c, BN * BPER);
    chk(ru_p + ru_n == BN * (BPER - 2) && ((ru_p - ru_n) % BDIFF) == 0,
        "R3 run-up pulse widths", ru_p + ru_n, BN * (BPER - 2));
    chk(rise_p == BN + 2 && rise_n == BN + 2, "R4 constant toggles", rise_p * 100 + rise_n,
        (BN + 2) * 101);
    chk(bbm == 0, "R5 break-before-make", bbm, 0);
    chk(ov_up == 0 && cn >= 1, "R6 upward stage stop", ov_up, 0);
    chk(ext_c == ext, "R7 extension cycles", ext_c, ext);
    chk(ov_fine == 0 && cf >= 1, "R8 fine slope stop", ov_fine, 0);
    chk(zbad == 0, "R10 zero select during reading", zbad, 0);
    chk(res_zero === ez, "R10 reading type", int'(res_zero), int'(ez));
    if (ez) begin
      expv = raw;
      zero_ref = raw;
    end else expv = raw - zero_ref;
    chk(int'(result) == expv, ez ? "R9 R11 zero result" : "R9 R11 signal result",
        int'(result), expv);
    rd_idx++;
    if (chain) start = 1'b1;
    clear_stats();
  endtask

  task automatic t_reset();
    chk(!sw_in && !sw_pos && !sw_neg && !int_rst && !sel_zero, "R1 selects idle",
        int'({sw_in, sw_pos, sw_neg, int_rst, sel_zero}), 0);
    chk(!busy && !done && !res_zero && result == 0, "R1 status and result",
        int'(result), 0);
  endtask

  task automatic t_signals();
    logic signed [23:0] r;
    run_reading(17, 0, 1'b0, 1'b0, 1'b0, r);   // zero reading, input ignored
    run_reading(20, 0, 1'b0, 1'b0, 1'b0, r_hi);
    run_reading(-20, 0, 1'b0, 1'b0, 1'b0, r_lo);
    chk(r_hi > r_lo, "R9 result follows input sign", int'(r_hi), int'(r_lo));
  endtask

  task automatic t_extension();
    logic signed [23:0] r;
    run_reading(5, 3, 1'b0, 1'b0, 1'b0, r);    // zero reading, extension 3
    run_reading(-9, 3, 1'b0, 1'b0, 1'b0, r);
  endtask

  task automatic t_start_busy();
    logic signed [23:0] r;
    int d0;
    d0 = done_tot;
    run_reading(11, 1, 1'b1, 1'b0, 1'b0, r);
    repeat (20) @(negedge clk);
    chk(!busy && done_tot == d0 + 1, "R12 start while busy ignored", done_tot - d0, 1);
  endtask

  task automatic t_start_at_done();
    logic signed [23:0] r;
    run_reading(0, 2, 1'b0, 1'b1, 1'b0, r);    // zero reading, chained
    run_reading(14, 2, 1'b0, 1'b0, 1'b1, r);   // accepted in the done cycle
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signals();
    t_extension();
    t_start_busy();
    t_start_at_done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule